// File: doc/BRIEF.md
# Programmable Event Divider with Transmit Offset

This block divides a stream of input events by a programmable modulus. The events come from a prescaled oscillator in a frequency synthesizer loop. A down-counter holds the number of events that remain in the current output period. On the event that ends a period, the block emits one divided pulse and reloads the counter with the effective modulus.

The effective modulus is the 14-bit program word plus an optional fixed offset of 856, kept to 14 bits. A transmit/receive select chooses the offset, which shifts the synthesized frequency by an intermediate-frequency step. Driving the select low adds the offset. Driving it high, which is also the idle level of an unconnected select, adds nothing.

The program word and the select are sampled only on the reloading event. A host can therefore change them at any time without shortening or stretching the period in progress.

Top module: `divn_event_div`

## Requirements
- R1: A synchronous active-high reset clears the divided output to 0 and empties the counter. The first input event after reset therefore produces an output pulse and loads the effective modulus.
- R2: With `tr_sel_i` low, the effective modulus is `prog_word_i` + 856. Bit 0 of `prog_word_i` is the least significant bit.
- R3: With `tr_sel_i` high, the effective modulus equals `prog_word_i` with no offset.
- R4: The sum of program word and offset is truncated to 14 bits, so it wraps modulo 16384. For example, 16383 + 856 gives 855, and 15528 + 856 gives 0.
- R5: With an effective modulus P of 2 or more, exactly one output pulse occurs for every P input events. `fv_o` is high during the clock cycle after the reloading event and for that cycle only.
- R6: A change to `prog_word_i` or `tr_sel_i` has no effect on the period in progress. The change is applied at the next reloading event, including a change presented in the same cycle as that event.
- R7: An effective modulus of 0 or 1 divides by one: every input event produces an output pulse.
- R8: Clock cycles without an input event leave the count unchanged and keep `fv_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fin_evt_i | input | 1 | Single-cycle input event strobe |
| prog_word_i | input | 14 | Programmed modulus, bit 0 least significant |
| tr_sel_i | input | 1 | 0 adds the 856 offset, 1 adds none |
| fv_o | output | 1 | Divided pulse, one clock wide, registered |

## Verification
Two functions can fall in the same cycle: reloading the counter and changing the program word or the select. The bench provokes this by changing the program word on the exact cycle of the reloading event. It judges the result by measuring the length of the following period, which must reflect the new modulus. The bench also changes the program word partway through a period and confirms that the period still ends on the old count. The bench exercises reset arriving mid-count, where reset and counting meet, by checking that the next event fires.

// File: rtl/divn_pkg.sv
package divn_pkg;
  localparam int DEF_CNT_W  = 14;
  localparam int DEF_OFFSET = 856;
endpackage

// File: rtl/divn_preset_add.sv
module divn_preset_add #(
  parameter int W      = divn_pkg::DEF_CNT_W,
  parameter int OFFSET = divn_pkg::DEF_OFFSET
) (
  input  logic [W-1:0] prog_i,
  input  logic         tr_i,
  output logic [W-1:0] preset_o
);
  localparam int          OFF_MOD = OFFSET % (2 ** W);
  localparam logic [W-1:0] OFF_W  = W'(OFF_MOD);

  generate
    if (OFF_MOD == 0) begin : g_no_off
      assign preset_o = prog_i;
    end else begin : g_off
      // Sum keeps W bits, so it wraps.
      assign preset_o = tr_i ? prog_i : (prog_i + OFF_W);
    end
  endgenerate
endmodule

// File: rtl/divn_down_cnt.sv
module divn_down_cnt #(
  parameter int W = divn_pkg::DEF_CNT_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         evt_i,
  input  logic [W-1:0] preset_i,
  output logic         reload_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  logic         last_w;

  assign last_w   = (cnt_q <= ONE);
  assign reload_o = evt_i && last_w;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (evt_i) begin
      if (last_w) cnt_q <= preset_i;
      else        cnt_q <= cnt_q - ONE;
    end
  end

  // R5
  dec_step_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !evt_i |=> $stable(cnt_q));

  // R6
  reload_take_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i && cnt_q <= ONE) |=> (cnt_q == $past(preset_i)));
endmodule

// File: rtl/divn_pulse_reg.sv
module divn_pulse_reg (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic pulse_o
);
  logic pulse_q;

  always_ff @(posedge clk) begin
    if (rst) pulse_q <= 1'b0;
    else     pulse_q <= fire_i;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/divn_event_div.sv
module divn_event_div #(
  parameter int CNT_W  = divn_pkg::DEF_CNT_W,
  parameter int OFFSET = divn_pkg::DEF_OFFSET
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fin_evt_i,
  input  logic [CNT_W-1:0] prog_word_i,
  input  logic             tr_sel_i,
  output logic             fv_o
);
  localparam logic [CNT_W-1:0] OFF_W = CNT_W'(OFFSET % (2 ** CNT_W));
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] preset_w;
  logic [CNT_W-1:0] cnt_w;
  logic             reload_w;

  divn_preset_add #(.W(CNT_W), .OFFSET(OFFSET)) u_add (
    .prog_i   (prog_word_i),
    .tr_i     (tr_sel_i),
    .preset_o (preset_w)
  );

  divn_down_cnt #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .evt_i    (fin_evt_i),
    .preset_i (preset_w),
    .reload_o (reload_w),
    .cnt_o    (cnt_w)
  );

  divn_pulse_reg u_out (
    .clk     (clk),
    .rst     (rst),
    .fire_i  (reload_w),
    .pulse_o (fv_o)
  );

  // R5
  pulse_src_chk: assert property (@(posedge clk) disable iff (rst)
    fv_o |-> $past(fin_evt_i));

  // R3
  no_offset_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_w && tr_sel_i) |=> (cnt_w == $past(prog_word_i)));

  // R2
  offset_add_chk: assert property (@(posedge clk) disable iff (rst)
    (reload_w && !tr_sel_i) |=> (cnt_w == $past(prog_word_i) + OFF_W));

  // R7
  div_one_chk: assert property (@(posedge clk) disable iff (rst)
    (fin_evt_i && cnt_w <= ONE) |=> fv_o);

  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !fin_evt_i |=> !fv_o);
endmodule

// File: tb/divn_event_div_tb.sv
module divn_event_div_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fin = 1'b0;
  logic [13:0] prog = 14'h3fff;
  logic        tr = 1'b1;
  logic        fv;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2 clk = ~clk;

  divn_event_div dut_i (
    .clk(clk), .rst(rst), .fin_evt_i(fin),
    .prog_word_i(prog), .tr_sel_i(tr), .fv_o(fv)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_event(output logic got);
    @(negedge clk) fin = 1'b1;
    @(negedge clk) fin = 1'b0;
    got = fv;
  endtask

  // Checks that the next p events fire only on the last one.
  task automatic expect_period(int p, string req);
    logic got;
    int   early = 0;
    for (int i = 1; i <= p; i++) begin
      send_event(got);
      if (i < p && got) early++;
      if (i == p) chk({req, " fire at end"}, int'(got), 1);
    end
    chk({req, " no early fire"}, early, 0);
  endtask

  task automatic restart(int p, logic t, string req);
    logic got;
    prog = 14'(p); tr = t;
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk({req, " fv low after reset"}, int'(fv), 0);
    send_event(got);
    chk({req, " first event fires"}, int'(got), 1);
  endtask

  task automatic t_reset;
    restart(5, 1'b1, "R1");
  endtask

  task automatic t_no_offset;
    logic got;
    restart(5, 1'b1, "R3");
    expect_period(5, "R3");
    expect_period(5, "R5");
    @(negedge clk);
    chk("R5 pulse one cycle wide", int'(fv), 0);
    got = 1'b0;
  endtask

  task automatic t_offset;
    restart(4, 1'b0, "R2");
    expect_period(860, "R2");
  endtask

  task automatic t_wrap;
    restart(16383, 1'b0, "R4");
    expect_period(855, "R4");
    restart(15528, 1'b0, "R4");
    expect_period(1, "R4 zero preset");
    expect_period(1, "R4 zero preset again");
  endtask

  task automatic t_div_one;
    restart(0, 1'b1, "R7");
    expect_period(1, "R7 zero");
    expect_period(1, "R7 zero");
    restart(1, 1'b1, "R7");
    expect_period(1, "R7 one");
    expect_period(1, "R7 one");
  endtask

  task automatic t_mid_change;
    logic got;
    restart(6, 1'b1, "R6");
    send_event(got);
    send_event(got);
    prog = 14'd3;
    tr = 1'b1;
    expect_period(4, "R6 old count kept");
    expect_period(3, "R6 new count");
  endtask

  task automatic t_same_cycle;
    logic got;
    restart(4, 1'b1, "R6");
    send_event(got);
    send_event(got);
    send_event(got);
    prog = 14'd2;
    send_event(got);
    chk("R6 reload event fires", int'(got), 1);
    expect_period(2, "R6 same-cycle change applied");
  endtask

  task automatic t_idle;
    logic got;
    int   hi = 0;
    restart(3, 1'b1, "R8");
    for (int i = 0; i < 3; i++) begin
      repeat (10) begin
        @(negedge clk);
        if (fv) hi++;
      end
      send_event(got);
      if (i == 2) chk("R8 fires after gaps", int'(got), 1);
    end
    chk("R8 fv low while idle", hi, 0);
  endtask

  task automatic t_reset_mid;
    logic got;
    restart(9, 1'b1, "R1");
    send_event(got);
    send_event(got);
    restart(9, 1'b1, "R1 mid-count");
    expect_period(9, "R1 period after reset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_no_offset;
    t_offset;
    t_wrap;
    t_div_one;
    t_mid_change;
    t_same_cycle;
    t_idle;
    t_reset_mid;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule